// File: doc/BRIEF.md
# Strided Rectangle DMA Line Sequencer

This block turns a rectangular transfer descriptor into a stream of line requests for one DMA channel. The descriptor holds a start address, a line length, a number of lines and a gap (stride) inserted after each line. A start request, optionally held back until an external synchronisation pulse, begins the walk. The block then offers one request per line on a valid/ready interface. Each request carries that line's base address and its length in bus words, so the frontend behind it can issue bursts longer than one beat.

While a pattern runs, the block reports busy. It raises a one-cycle done indication when a full pattern ends, which interrupt logic can use. In loop mode the walk starts again from the first line rather than stopping. It keeps going until software clears the loop bit. The descriptor is captured when the walk starts, so software may stage the next descriptor while the current one runs.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_valid, busy and done are all 0.
- R2: The cycle after a start is launched with a nonzero length and count, req_valid is 1, req_addr equals the captured start address and req_len equals the captured line length.
- R3: The request for line n (counting from 0) carries req_addr = start + n*(line_len + stride), truncated to ADDR_W bits, so the address wraps around.
- R4: Exactly line_cnt requests are accepted per pattern. While req_valid is 1 and req_ready is 0, req_addr and req_len hold their values, and the walk advances only on a cycle where both are 1.
- R5: With cfg_sync_en = 1, a start request does not launch until a cycle with sync_pulse = 1; a sync pulse in the same cycle as the start launches at once. With cfg_sync_en = 0, a start launches in the cycle it is requested.
- R6: busy is 1 from the cycle after launch until the cycle after the last line request is accepted, and equals req_valid.
- R7: done is 1 for exactly the one cycle after the last line of a pattern is accepted.
- R8: A launch with line_cnt = 0 or line_len = 0 produces no request, leaves busy at 0 and gives done = 1 in the cycle after launch.
- R9: If cfg_loop is 1 when the last line is accepted, done pulses, busy stays 1 and the next request restarts at the start address.
- R10: Start requests made while busy have no effect.
- R11: Changes to the address, length, count or stride inputs after launch do not affect the running pattern.
- R12: A sync pulse with no waiting start request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_addr | input | ADDR_W | Address of the first line, in words |
| cfg_line_len | input | LEN_W | Words per line |
| cfg_line_cnt | input | CNT_W | Number of lines |
| cfg_stride | input | ADDR_W | Words skipped between the end of one line and the next |
| cfg_sync_en | input | 1 | Hold starts until a sync pulse |
| cfg_loop | input | 1 | Restart the pattern after its last line |
| start_req | input | 1 | Request to start a pattern |
| sync_pulse | input | 1 | External synchronisation event |
| req_valid | output | 1 | A line request is offered |
| req_ready | input | 1 | Downstream accepts the offered request |
| req_addr | output | ADDR_W | Base address of the offered line |
| req_len | output | LEN_W | Length of the offered line |
| busy | output | 1 | A pattern is running |
| done | output | 1 | One-cycle pulse at the end of a pattern |

## Verification
The bench aims at the end of the address space. A design that wraps wrongly, or that drops carry bits, emits a bad address on the lines after the wrap. Random backpressure is applied so that a walker that advances on valid alone would skip lines. Zero length and zero count are each tried, since a naive design would offer a request of zero or of 2^CNT_W lines. Sync pulses are placed before, with and after the start request, and loop mode is cleared in the middle of a run. Together these catch a start that slips past the gate, a launch that occurs on the wrong cycle, and a loop that does not stop.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/dma2d_start_gate.sv
module dma2d_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic sync_en,
  input  logic sync_pulse,
  input  logic walker_busy,
  output logic launch,
  output logic waiting
);
  logic wait_q;
  logic direct_go;
  logic held_go;
  logic arm;

  assign direct_go = start_req && (!sync_en || sync_pulse);
  assign held_go   = wait_q && sync_pulse;
  assign launch    = !walker_busy && (direct_go || held_go);
  assign arm       = !walker_busy && start_req && sync_en && !sync_pulse;
  assign waiting   = wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wait_q <= 1'b0;
    else if (launch) wait_q <= 1'b0;
    else if (arm)    wait_q <= 1'b1;
  end

  // R10: nothing launches while a pattern runs
  p_no_launch_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    walker_busy |-> !launch);

  // R5: a launch with sync enabled always coincides with a sync pulse
  p_sync_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && sync_en) |-> sync_pulse);

  // R12: a sync pulse without a waiting or new start launches nothing
  p_lone_sync_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && !wait_q && !start_req) |-> !launch);
endmodule

// File: rtl/dma2d_line_walker.sv
module dma2d_line_walker
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] cfg_start_addr,
  input  logic [LEN_W-1:0]  cfg_line_len,
  input  logic [CNT_W-1:0]  cfg_line_cnt,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic              cfg_loop,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done
);
  localparam int WIDE_W = (ADDR_W > LEN_W) ? ADDR_W : LEN_W;

  function automatic logic [ADDR_W-1:0] line_step(input logic [LEN_W-1:0] len,
                                                  input logic [ADDR_W-1:0] gap);
    logic [WIDE_W-1:0] wide;
    wide = WIDE_W'(len) + WIDE_W'(gap);
    return wide[ADDR_W-1:0];
  endfunction

  function automatic logic is_empty(input logic [LEN_W-1:0] len,
                                    input logic [CNT_W-1:0] cnt);
    return (len == '0) || (cnt == '0);
  endfunction

  walk_state_e       state_q;
  logic [ADDR_W-1:0] snap_start_q;
  logic [ADDR_W-1:0] snap_step_q;
  logic [LEN_W-1:0]  snap_len_q;
  logic [CNT_W-1:0]  snap_last_q;
  logic [CNT_W-1:0]  line_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;

  logic fire;
  logic last_line;
  logic fire_last;
  logic launch_run;
  logic launch_empty;
  logic restart;

  assign fire         = req_valid && req_ready;
  assign last_line    = (line_q == snap_last_q);
  assign fire_last    = fire && last_line;
  assign restart      = fire_last && cfg_loop;
  assign launch_run   = launch && (state_q == WALK_IDLE) && !is_empty(cfg_line_len, cfg_line_cnt);
  assign launch_empty = launch && (state_q == WALK_IDLE) && is_empty(cfg_line_len, cfg_line_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= WALK_IDLE;
      snap_start_q <= '0;
      snap_step_q  <= '0;
      snap_len_q   <= '0;
      snap_last_q  <= '0;
      line_q       <= '0;
      addr_q       <= '0;
      done_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        WALK_IDLE: begin
          if (launch_run) begin
            state_q      <= WALK_RUN;
            snap_start_q <= cfg_start_addr;
            snap_step_q  <= line_step(cfg_line_len, cfg_stride);
            snap_len_q   <= cfg_line_len;
            snap_last_q  <= cfg_line_cnt - 1'b1;
            line_q       <= '0;
            addr_q       <= cfg_start_addr;
          end else if (launch_empty) begin
            done_q <= 1'b1;
          end
        end
        WALK_RUN: begin
          if (fire) begin
            if (last_line) begin
              done_q <= 1'b1;
              line_q <= '0;
              addr_q <= snap_start_q;
              if (!cfg_loop) state_q <= WALK_IDLE;
            end else begin
              line_q <= line_q + 1'b1;
              addr_q <= addr_q + snap_step_q;
            end
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  assign req_valid = (state_q == WALK_RUN);
  assign busy      = (state_q == WALK_RUN);
  assign req_addr  = addr_q;
  assign req_len   = snap_len_q;
  assign done      = done_q;

  // R4: an offered request holds until it is taken
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

  // R2: first request carries the start address captured at launch
  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_run |=> (req_valid && req_addr == $past(cfg_start_addr)));

  // R6 / R7: busy only falls together with a done pulse
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8: empty descriptor finishes at once without running
  p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    launch_empty |=> (done && !busy));

  // R9: loop restart keeps running from the start address
  p_loop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (busy && done && req_addr == snap_start_q));

  // R3: each accepted non-final line moves the address by one step
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last_line) |=> (req_addr == $past(req_addr) + snap_step_q));
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_start_addr,
  input  logic [LEN_W-1:0]  cfg_line_len,
  input  logic [CNT_W-1:0]  cfg_line_cnt,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic              cfg_sync_en,
  input  logic              cfg_loop,
  input  logic              start_req,
  input  logic              sync_pulse,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done
);
  logic launch;
  logic waiting;
  logic walker_busy;

  dma2d_start_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .sync_en     (cfg_sync_en),
    .sync_pulse  (sync_pulse),
    .walker_busy (walker_busy),
    .launch      (launch),
    .waiting     (waiting)
  );

  dma2d_line_walker #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .CNT_W  (CNT_W)
  ) u_walk (
    .clk            (clk),
    .rst_n          (rst_n),
    .launch         (launch),
    .cfg_start_addr (cfg_start_addr),
    .cfg_line_len   (cfg_line_len),
    .cfg_line_cnt   (cfg_line_cnt),
    .cfg_stride     (cfg_stride),
    .cfg_loop       (cfg_loop),
    .req_ready      (req_ready),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_len        (req_len),
    .busy           (walker_busy),
    .done           (done)
  );

  assign busy = walker_busy;

  // R5: a waiting start never coexists with a running pattern
  p_wait_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !walker_busy);

  // R6: busy and valid always agree
  p_busy_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy == req_valid);
endmodule

// File: tb/tb_dma2d_addr_gen.sv
module tb_dma2d_addr_gen;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_start_addr = '0;
  logic [LW-1:0] cfg_line_len = '0;
  logic [CW-1:0] cfg_line_cnt = '0;
  logic [AW-1:0] cfg_stride = '0;
  logic          cfg_sync_en = 1'b0;
  logic          cfg_loop = 1'b0;
  logic          start_req = 1'b0;
  logic          sync_pulse = 1'b0;
  logic          req_ready = 1'b1;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic          busy;
  logic          done;

  dma2d_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_start_addr(cfg_start_addr), .cfg_line_len(cfg_line_len),
    .cfg_line_cnt(cfg_line_cnt), .cfg_stride(cfg_stride),
    .cfg_sync_en(cfg_sync_en), .cfg_loop(cfg_loop),
    .start_req(start_req), .sync_pulse(sync_pulse),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string scen = "R1";
  bit rnd_ready = 1'b0;

  // behavioural reference
  bit              m_run = 0;
  bit              m_wait = 0;
  bit              m_done = 0;
  longint unsigned m_start = 0;
  longint unsigned m_len = 0;
  longint unsigned m_stride = 0;
  longint unsigned m_cnt = 0;
  longint unsigned m_idx = 0;
  int              fires = 0;
  int              dones = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_wait = 0; m_done = 0; m_idx = 0;
    end else begin
      bit go;
      m_done = 0;
      if (m_run) begin
        if (req_ready) begin
          fires++;
          if (m_idx == m_cnt - 1) begin
            m_done = 1; dones++;
            m_idx = 0;
            if (!cfg_loop) m_run = 0;
          end else m_idx++;
        end
      end else begin
        go = (start_req && (!cfg_sync_en || sync_pulse)) || (m_wait && sync_pulse);
        if (go) begin
          m_wait = 0;
          if (cfg_line_len == 0 || cfg_line_cnt == 0) begin
            m_done = 1; dones++;
          end else begin
            m_run = 1; m_idx = 0;
            m_start = cfg_start_addr; m_len = cfg_line_len;
            m_stride = cfg_stride; m_cnt = cfg_line_cnt;
          end
        end else if (start_req && cfg_sync_en && !sync_pulse) m_wait = 1;
      end
    end
  end

  task automatic check(input bit ok, input string what, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", scen, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    longint unsigned ea;
    ea = (m_start + m_idx * (m_len + m_stride)) & ((64'd1 << AW) - 1);
    check(req_valid == m_run, "valid R4", req_valid, m_run);
    check(busy == m_run, "busy R6", busy, m_run);
    check(done == m_done, "done R7", done, m_done);
    if (m_run && req_valid) begin
      check(req_addr == ea, "addr R3", req_addr, ea);
      check(req_len == m_len, "len R2", req_len, m_len);
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
    req_ready = rnd_ready ? 1'($urandom_range(0, 1)) : 1'b1;
  endtask

  task automatic pulse_start();
    start_req = 1'b1; tick(); start_req = 1'b0;
  endtask

  task automatic run_to_idle();
    for (int i = 0; i < 5000 && (m_run || busy); i++) tick();
    tick(); tick();
  endtask

  task automatic setup(input longint unsigned s, input int l, input int c,
                       input longint unsigned g);
    cfg_start_addr = AW'(s); cfg_line_len = LW'(l);
    cfg_line_cnt = CW'(c); cfg_stride = AW'(g);
  endtask

  initial begin
    int base_f;
    int base_d;
    // R1: reset values
    scen = "R1 reset";
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R2 R3: basic rectangle, full throughput
    scen = "R2 R3 basic";
    setup(32'h1000, 4, 3, 8);
    base_f = fires;
    pulse_start();
    run_to_idle();
    check(fires - base_f == 3, "R4 request count", fires - base_f, 3);

    // R4: random backpressure, zero stride
    scen = "R4 backpressure";
    rnd_ready = 1'b1;
    setup(32'h2000_0000, 16, 5, 0);
    base_f = fires;
    pulse_start();
    run_to_idle();
    check(fires - base_f == 5, "R4 request count", fires - base_f, 5);

    // R3: wrap at the top of the address space
    scen = "R3 wrap";
    setup(32'hFFFF_FFF0, 8, 4, 8);
    pulse_start();
    run_to_idle();
    rnd_ready = 1'b0;

    // R8: empty descriptors
    scen = "R8 zero count";
    setup(32'h40, 4, 0, 0);
    base_d = dones;
    pulse_start();
    tick(); tick();
    check(dones - base_d == 1, "R8 done count", dones - base_d, 1);
    check(busy == 1'b0, "R8 busy", busy, 0);
    scen = "R8 zero len";
    setup(32'h40, 0, 6, 0);
    pulse_start();
    tick(); tick();
    check(busy == 1'b0, "R8 busy", busy, 0);

    // R12: lone sync pulse
    scen = "R12 lone sync";
    cfg_sync_en = 1'b1;
    setup(32'h500, 2, 2, 1);
    sync_pulse = 1'b1; tick(); sync_pulse = 1'b0;
    tick(); tick();
    check(busy == 1'b0, "R12 busy", busy, 0);

    // R5: start waits for sync
    scen = "R5 sync wait";
    pulse_start();
    repeat (6) tick();
    check(busy == 1'b0, "R5 held", busy, 0);
    sync_pulse = 1'b1; tick(); sync_pulse = 1'b0;
    tick();
    check(busy == 1'b1, "R5 released", busy, 1);
    run_to_idle();
    scen = "R5 sync same cycle";
    start_req = 1'b1; sync_pulse = 1'b1; tick();
    start_req = 1'b0; sync_pulse = 1'b0;
    tick();
    check(busy == 1'b1, "R5 immediate", busy, 1);
    run_to_idle();
    cfg_sync_en = 1'b0;

    // R10 R11: start during run ignored, config changes ignored
    scen = "R10 R11 busy start";
    rnd_ready = 1'b1;
    setup(32'h8000, 3, 6, 5);
    base_f = fires;
    pulse_start();
    tick();
    setup(32'h9999, 7, 2, 1);
    pulse_start();
    repeat (3) tick();
    pulse_start();
    run_to_idle();
    check(fires - base_f == 6, "R10 R11 request count", fires - base_f, 6);
    rnd_ready = 1'b0;

    // R9: loop mode, stopped by clearing the loop bit
    scen = "R9 loop";
    setup(32'h300, 2, 2, 2);
    cfg_loop = 1'b1;
    base_d = dones;
    pulse_start();
    repeat (9) tick();
    check(busy == 1'b1, "R9 still busy", busy, 1);
    cfg_loop = 1'b0;
    run_to_idle();
    check(dones - base_d >= 3, "R9 done pulses", dones - base_d, 3);
    scen = "R9 loop single line";
    setup(32'h10, 1, 1, 0);
    cfg_loop = 1'b1;
    pulse_start();
    repeat (5) tick();
    cfg_loop = 1'b0;
    run_to_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule